// File: doc/BRIEF.md
# Shadow Memory Attribute Controller

This block holds the configuration registers that steer shadow memory in the upper 256 KB of the first megabyte of a PC address map (0xC0000 to 0xFFFFF), and turns them into per-address access attributes. Software reaches the registers through two I/O ports. A write to the index port selects a register. Reads and writes on the data port then act on the selected register. Only five registers, at indices 0x10 to 0x14, can be written. Every other index reads back as zero.

Given a 20-bit memory address, the block decides where a read is served from (internal memory or the external bus) and where a write goes (internal memory, the external bus, or nowhere). The top 64 KB segment follows its own pair of control bits. Each of the three lower 64 KB segments has an enable bit and a write-protect bit, and is divided into four 16 KB chunks that are shadowed one by one. The attribute outputs are combinational from the address and the registered configuration. A configuration write therefore shows up on the outputs right after the clock edge that captures it.

Top module: `shadow_attr_ctrl`

## Requirements
- R1: An I/O write to port 0x22 loads the 8-bit index. An I/O write to port 0x24 stores the data byte in the selected register. Either result is visible after the next rising clock edge.
- R2: Data-port writes take effect only while the index is 0x10 to 0x14. Writes with any other index change no register, and such indices always read back as 0x00.
- R3: While io_rd is high and io_addr is 0x24, io_rdata returns the selected register. In every other case io_rdata is 0xFF.
- R4: After reset the index is 0x00, register 0x10 holds 0x3F, register 0x11 holds 0xF0, and registers 0x12 to 0x14 hold 0x00.
- R5: The write attribute wr_sel is encoded as 2'b00 for the external bus, 2'b01 for internal memory and 2'b10 for disabled. The read attribute rd_int is 1 for internal memory and 0 for the external bus. For addresses 0xF0000 to 0xFFFFF, the rules are:
  - if register 0x11 bit 7 is set, rd_int=0 and wr_sel=01;
  - otherwise rd_int=1, and wr_sel is 01 if register 0x14 bit 7 is set and 10 if it is clear.
- R6: Register 0x11 holds the segment enables: bit 4 for 0xC0000, bit 5 for 0xD0000 and bit 6 for 0xE0000. While a segment's enable is clear, every address in that segment gives rd_int=0 and wr_sel=00.
- R7: Within an enabled segment, the chunk number is address bits 15:14. The shadow bit for chunk i is:
  - register 0x13 bit 4+i for 0xC0000;
  - register 0x12 bit i for 0xD0000;
  - register 0x12 bit 4+i for 0xE0000.
  A clear shadow bit gives rd_int=0 and wr_sel=00.
- R8: A shadowed chunk gives rd_int=1. Its wr_sel is 10 if the segment's write-protect bit is set and 01 otherwise. The write-protect bits are in register 0x11: bit 0 for 0xC0000, bit 1 for 0xD0000 and bit 2 for 0xE0000.
- R9: For addresses below 0xC0000, below_win=1, rd_int=0 and wr_sel=00. For addresses from 0xC0000 upward, below_win=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| mem_addr | input | 20 | Memory address being decoded |
| rd_int | output | 1 | 1 = read from internal memory, 0 = external bus |
| wr_sel | output | 2 | Write target: 00 external, 01 internal, 10 disabled |
| below_win | output | 1 | Address lies below the shadow window |

## Verification
The lower-segment decode is swept over every chunk of all three segments. Each chunk is tried with each combination of segment enable, chunk bit and write-protect bit. This sweep separates:
- a wrong bit mapping, because a neighbouring chunk or segment would answer instead;
- swapped priority between enable and chunk bit;
- a write-protect bit assigned to the wrong segment.

The top segment is tried with three settings of its two control bits, which separates the external-read case from the two internal-read write cases. Writes to indices just outside 0x10 to 0x14, and to 0xFF, are followed by read-back of both the ignored index and the live registers, which exposes a range decode that is off by one. Addresses just below and at 0xC0000 check the window edge.

// File: rtl/shadow_pkg.sv
package shadow_pkg;
    localparam int unsigned NREG     = 5;
    localparam int unsigned OFF_W    = $clog2(NREG);
    localparam logic [7:0]  REG_BASE = 8'h10;

    // slot numbers within the register file (index - REG_BASE)
    localparam int unsigned S_MISC = 0;
    localparam int unsigned S_CTL  = 1;
    localparam int unsigned S_LOW  = 2;
    localparam int unsigned S_OPT  = 3;
    localparam int unsigned S_TOP  = 4;

    typedef logic [NREG-1:0][7:0] reg_bank_t;

    localparam reg_bank_t REG_RESET = {8'h00, 8'h00, 8'h00, 8'hF0, 8'h3F};

    typedef enum logic [1:0] {
        WR_EXT = 2'b00,
        WR_INT = 2'b01,
        WR_OFF = 2'b10
    } wr_tgt_e;

    typedef struct packed {
        logic [7:0] idx;
        reg_bank_t  regs;
    } cfg_t;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
    import shadow_pkg::*;
#(
    parameter int unsigned IO_W      = 16,
    parameter logic [15:0] IDX_PORT  = 16'h0022,
    parameter logic [15:0] DATA_PORT = 16'h0024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            io_wr,
    input  logic            io_rd,
    input  logic [IO_W-1:0] io_addr,
    input  logic [7:0]      io_wdata,
    output logic [7:0]      io_rdata,
    output logic [7:0]      cfg_idx,
    output reg_bank_t       cfg_regs
);
    cfg_t             cfg_d, cfg_q;
    logic [7:0]       off;
    logic             in_range;
    logic [OFF_W-1:0] slot;

    always_comb begin
        off      = cfg_q.idx - REG_BASE;
        in_range = (cfg_q.idx >= REG_BASE) && (off < 8'(NREG));
        slot     = off[OFF_W-1:0];

        cfg_d = cfg_q;
        if (io_wr && io_addr == IDX_PORT[IO_W-1:0]) begin
            cfg_d.idx = io_wdata;
        end else if (io_wr && io_addr == DATA_PORT[IO_W-1:0] && in_range) begin
            cfg_d.regs[slot] = io_wdata;
        end

        if (io_rd && io_addr == DATA_PORT[IO_W-1:0])
            io_rdata = in_range ? cfg_q.regs[slot] : 8'h00;
        else
            io_rdata = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.idx  <= 8'h00;
            cfg_q.regs <= REG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_idx  = cfg_q.idx;
    assign cfg_regs = cfg_q.regs;
endmodule

// File: rtl/shadow_decode.sv
module shadow_decode
    import shadow_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] mem_addr,
    input  reg_bank_t         cfg_regs,
    output logic              rd_int,
    output logic [1:0]        wr_sel,
    output logic              below_win
);
    localparam int unsigned NSEG_LO = 3;

    logic [NSEG_LO-1:0] seg_rd;
    wr_tgt_e            seg_wr [NSEG_LO];
    logic [1:0]         chunk;
    logic [1:0]         seg;
    logic               in_win;

    assign chunk  = mem_addr[15:14];
    assign seg    = mem_addr[17:16];
    assign in_win = (mem_addr[ADDR_W-1:18] == '1);

    for (genvar s = 0; s < NSEG_LO; s++) begin : g_seg
        logic [3:0] chunk_bits;
        logic       en, wp;
        if (s == 0) begin : g_c
            assign chunk_bits = cfg_regs[S_OPT][7:4];
        end else if (s == 1) begin : g_d
            assign chunk_bits = cfg_regs[S_LOW][3:0];
        end else begin : g_e
            assign chunk_bits = cfg_regs[S_LOW][7:4];
        end
        assign en = cfg_regs[S_CTL][4+s];
        assign wp = cfg_regs[S_CTL][s];

        always_comb begin
            if (en && chunk_bits[chunk]) begin
                seg_rd[s] = 1'b1;
                seg_wr[s] = wp ? WR_OFF : WR_INT;
            end else begin
                seg_rd[s] = 1'b0;
                seg_wr[s] = WR_EXT;
            end
        end
    end

    always_comb begin
        below_win = !in_win;
        rd_int    = 1'b0;
        wr_sel    = WR_EXT;
        if (in_win) begin
            if (seg == 2'd3) begin
                if (cfg_regs[S_CTL][7]) begin
                    rd_int = 1'b0;
                    wr_sel = WR_INT;
                end else begin
                    rd_int = 1'b1;
                    wr_sel = cfg_regs[S_TOP][7] ? WR_INT : WR_OFF;
                end
            end else begin
                rd_int = seg_rd[seg];
                wr_sel = seg_wr[seg];
            end
        end
    end
endmodule

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl
    import shadow_pkg::*;
#(
    parameter int unsigned IO_W   = 16,
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [IO_W-1:0]   io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    output logic              rd_int,
    output logic [1:0]        wr_sel,
    output logic              below_win
);
    logic [7:0] cfg_idx;
    reg_bank_t  cfg_regs;

    shadow_cfg_regs #(.IO_W(IO_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .cfg_idx  (cfg_idx),
        .cfg_regs (cfg_regs)
    );

    shadow_decode #(.ADDR_W(ADDR_W)) u_dec (
        .mem_addr  (mem_addr),
        .cfg_regs  (cfg_regs),
        .rd_int    (rd_int),
        .wr_sel    (wr_sel),
        .below_win (below_win)
    );
endmodule

// File: rtl/shadow_attr_chk.sv
module shadow_attr_chk
    import shadow_pkg::*;
#(
    parameter int unsigned IO_W   = 16,
    parameter int unsigned ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic              io_rd,
    input logic [IO_W-1:0]   io_addr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rd_int,
    input logic [1:0]        wr_sel,
    input logic              below_win,
    input logic [7:0]        cfg_idx,
    input reg_bank_t         cfg_regs
);
    logic ign_idx;
    assign ign_idx = (cfg_idx < REG_BASE) || (cfg_idx >= REG_BASE + 8'(NREG));

    p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h0022) |=> (cfg_idx == $past(io_wdata)));

    p_ignored_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h0024 && ign_idx) |=> $stable(cfg_regs));

    p_other_port_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_addr == 16'h0024) |-> (io_rdata == 8'hFF));

    p_top_ext_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[19:16] == 4'hF && cfg_regs[S_CTL][7]) |-> (!rd_int && wr_sel == 2'b01));

    p_seg_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[19:18] == 2'b11 && mem_addr[17:16] != 2'b11 &&
         !cfg_regs[S_CTL][4 + mem_addr[17:16]]) |-> (!rd_int && wr_sel == 2'b00));

    p_wr_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel != 2'b11);

    p_below_r9: assert property (@(posedge clk) disable iff (!rst_n)
        below_win |-> (!rd_int && wr_sel == 2'b00 && mem_addr < 20'hC0000));
endmodule

bind shadow_attr_ctrl shadow_attr_chk #(.IO_W(IO_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .mem_addr  (mem_addr),
    .rd_int    (rd_int),
    .wr_sel    (wr_sel),
    .below_win (below_win),
    .cfg_idx   (cfg_idx),
    .cfg_regs  (cfg_regs)
);

// File: tb/sim_shadow_attr_ctrl.sv
module sim_shadow_attr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [19:0] mem_addr = '0;
    logic        rd_int, below_win;
    logic [1:0]  wr_sel;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    shadow_attr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .mem_addr(mem_addr), .rd_int(rd_int), .wr_sel(wr_sel),
        .below_win(below_win)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] d);
        io_write(16'h0022, idx);
        io_write(16'h0024, d);
    endtask

    task automatic read_reg(input logic [7:0] idx, output logic [7:0] d);
        io_write(16'h0022, idx);
        io_rd = 1'b1; io_addr = 16'h0024;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic probe(input string req, input logic [19:0] a,
                         input logic exp_rd, input logic [1:0] exp_wr, input logic exp_below);
        mem_addr = a;
        #1;
        chk({req, " rd_int"}, int'(rd_int), int'(exp_rd));
        chk({req, " wr_sel"}, int'(wr_sel), int'(exp_wr));
        chk({req, " below_win"}, int'(below_win), int'(exp_below));
    endtask

    task automatic t_reset;
        logic [7:0] v;
        logic [7:0] exp_v [5] = '{8'h3F, 8'hF0, 8'h00, 8'h00, 8'h00};
        io_rd = 1'b1; io_addr = 16'h0024;
        #1 chk("R4 index 0 reads zero", int'(io_rdata), 0);
        io_rd = 1'b0;
        for (int i = 0; i < 5; i++) begin
            read_reg(8'h10 + 8'(i), v);
            chk("R4 reset value", int'(v), int'(exp_v[i]));
        end
        probe("R5 reset top", 20'hF1234, 1'b0, 2'b01, 1'b0);
        probe("R7 reset chunk off", 20'hC4000, 1'b0, 2'b00, 1'b0);
    endtask

    task automatic t_port_rw;
        logic [7:0] v;
        set_reg(8'h13, 8'hA5);
        read_reg(8'h13, v);
        chk("R1 data write/readback", int'(v), 8'hA5);
        set_reg(8'h10, 8'h5A);
        read_reg(8'h10, v);
        chk("R1 reg 0x10 write", int'(v), 8'h5A);
        io_rd = 1'b1; io_addr = 16'h0022;
        #1 chk("R3 index port read 0xFF", int'(io_rdata), 8'hFF);
        io_addr = 16'h0023;
        #1 chk("R3 other port read 0xFF", int'(io_rdata), 8'hFF);
        io_rd = 1'b0; io_addr = 16'h0024;
        #1 chk("R3 no strobe 0xFF", int'(io_rdata), 8'hFF);
    endtask

    task automatic t_ignored;
        logic [7:0] v;
        logic [7:0] bad [3] = '{8'h0F, 8'h15, 8'hFF};
        foreach (bad[k]) begin
            set_reg(bad[k], 8'hC3);
            read_reg(bad[k], v);
            chk("R2 ignored index reads zero", int'(v), 0);
            read_reg(8'h10, v);
            chk("R2 reg 0x10 untouched", int'(v), 8'h5A);
            read_reg(8'h13, v);
            chk("R2 reg 0x13 untouched", int'(v), 8'hA5);
            read_reg(8'h14, v);
            chk("R2 reg 0x14 untouched", int'(v), 8'h00);
        end
    endtask

    task automatic t_top;
        set_reg(8'h11, 8'h80);
        probe("R5 top ext read", 20'hFFFFF, 1'b0, 2'b01, 1'b0);
        set_reg(8'h11, 8'h00);
        set_reg(8'h14, 8'h00);
        probe("R5 top write off", 20'hF0000, 1'b1, 2'b10, 1'b0);
        set_reg(8'h14, 8'h80);
        probe("R5 top write int", 20'hF8000, 1'b1, 2'b01, 1'b0);
    endtask

    task automatic t_chunks;
        for (int s = 0; s < 3; s++)
            for (int c = 0; c < 4; c++)
                for (int en = 0; en < 2; en++)
                    for (int cb = 0; cb < 2; cb++)
                        for (int wp = 0; wp < 2; wp++) begin
                            logic [7:0] ctl, r12, r13;
                            logic       erd;
                            logic [1:0] ewr;
                            ctl = 8'((en << (4 + s)) | (wp << s));
                            r12 = 8'h00; r13 = 8'h00;
                            if (s == 0) r13 = 8'(cb << (4 + c));
                            else if (s == 1) r12 = 8'(cb << c);
                            else r12 = 8'(cb << (4 + c));
                            set_reg(8'h11, ctl);
                            set_reg(8'h12, r12);
                            set_reg(8'h13, r13);
                            if (en == 0) begin erd = 1'b0; ewr = 2'b00; end
                            else if (cb == 0) begin erd = 1'b0; ewr = 2'b00; end
                            else begin erd = 1'b1; ewr = wp ? 2'b10 : 2'b01; end
                            probe(en == 0 ? "R6 seg disabled" : (cb == 0 ? "R7 chunk bit" : "R8 shadow wp"),
                                  20'hC0000 + 20'(s * 20'h10000) + 20'(c * 20'h4000) + 20'h0ABC,
                                  erd, ewr, 1'b0);
                        end
    endtask

    task automatic t_below;
        set_reg(8'h11, 8'h77);
        set_reg(8'h12, 8'hFF);
        set_reg(8'h13, 8'hF0);
        probe("R9 just below window", 20'hBFFFF, 1'b0, 2'b00, 1'b1);
        probe("R9 low memory", 20'h00000, 1'b0, 2'b00, 1'b1);
        probe("R9 window start", 20'hC0000, 1'b1, 2'b10, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_port_rw();
        t_ignored();
        t_top();
        t_chunks();
        t_below();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule